// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block takes received Ethernet frames, presented as a byte stream with start, end and error markers, and stores them in system memory. It works through a circular ring of 16-byte descriptors that software places in memory. When a frame starts, the engine reads the descriptor at its current ring position and checks whether hardware owns it. If hardware owns it, the engine checks the buffer pointer, packs the frame bytes into word writes, and writes a completion word back. That word returns ownership to software and reports the stored length and any error flags. The engine then moves to the next descriptor.

Software programs a ring base address and fills the descriptors. It then watches for the write-back pulse and hands each descriptor back when it has consumed the frame. A descriptor carries its own end-of-ring flag, so software can pick any ring length. The memory side is a single-outstanding word request/acknowledge master. Frames that find no free descriptor are consumed and counted, so the byte source is never stalled for long.

Top module: `rxd_dma_writer`

## Requirements
- R1: Writing the base register takes the written address with its low 4 bits forced to zero. It also returns the ring position to entry 0, so the next frame uses the descriptor at the new base.
- R2: Descriptor k sits at base + 16*k. Word 0 (offset 0) holds the ownership flag in bit 31, set when hardware owns the entry. Word 1 (offset 4) holds the buffer size in bits 10:0 and the end-of-ring flag in bit 31. Word 2 (offset 8) holds the buffer byte address. All descriptor accesses are word reads or writes at word-aligned addresses.
- R3: Suppose the descriptor at the current position has bit 31 of word 0 clear when a frame starts. The whole frame is then accepted and discarded, with no memory write and no write-back pulse. The missed-frame counter rises by exactly one, and the ring position does not move.
- R4: A buffer address with bit 0 set, or with bit 1 clear (a multiple of 4), is rejected. The frame is discarded, and word 0 is written back as 0x1000_0000: ownership cleared, bit 28 set, length 0. The ring position then advances.
- R5: With a valid buffer address, frame byte i is stored at buffer address + i, in little-endian lane order. Every write enables only the byte lanes that carry frame bytes, so the bytes on either side of the stored data keep their old values.
- R6: A frame longer than the buffer size stores only the first size bytes. Bit 29 is set in the write-back, and bytes past the buffer are never written.
- R7: The write-back to word 0 clears bit 31. It puts the number of stored bytes in bits 10:0, and bit 30 is the error marker that came with the frame's last byte.
- R8: After a write-back to a descriptor whose end-of-ring flag is set, the next frame uses entry 0. Otherwise it uses the next entry.
- R9: The write-back pulse is high for exactly one cycle per descriptor write-back, in the cycle after that write is acknowledged.
- R10: Bytes that arrive while the engine is idle and carry no start marker are accepted and dropped, and no memory access results.
- R11: A memory request, once raised, keeps its address, direction, data and byte enables unchanged until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| base_we | input | 1 | Write strobe for the ring base register |
| base_addr | input | 32 | New ring base address (low 4 bits ignored) |
| rx_valid | input | 1 | A frame byte is presented |
| rx_ready | output | 1 | The presented byte is taken this cycle |
| rx_data | input | 8 | Frame byte |
| rx_sof | input | 1 | Byte is the first of a frame |
| rx_eof | input | 1 | Byte is the last of a frame |
| rx_err | input | 1 | Frame error flag, read with the last byte |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_be | output | 4 | Write byte enables |
| mem_ack | input | 1 | Request completed this cycle |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| wb_done | output | 1 | One-cycle pulse after each descriptor write-back |
| missed_count | output | MISS_W | Frames dropped for lack of a hardware-owned descriptor |

## Verification
The hardest case to reach is a frame arriving after the ring has wrapped onto a descriptor that software has not yet returned. The stimulus gets there by running frames through every entry of a short ring up to its end-of-ring entry. The next frames then land on entry 0, which the engine itself just handed back. The bench then re-arms that entry from the memory side and checks that reception resumes at the same position. A base rewrite in the middle of the ring, and a buffer holding exactly its size in bytes, are reached in the same way. A memory model with varying acknowledge latency checks every write against the buffer and descriptor that a behavioural model expects.

// File: rtl/rxd_pkg.sv
// Shared field positions and state encoding for the receive ring writer.
// Assumes a 32-bit memory word and 16-byte descriptors.
package rxd_pkg;
    localparam int OWN_BIT  = 31;   // word 0: hardware owns the entry
    localparam int ERR_BIT  = 30;   // word 0: frame error marker
    localparam int OVF_BIT  = 29;   // word 0: frame truncated
    localparam int BAD_BIT  = 28;   // word 0: buffer address rejected
    localparam int EOR_BIT  = 31;   // word 1: last entry of the ring
    localparam int LEN_W    = 11;   // length / size field width
    localparam int PAD_W    = 32 - 4 - LEN_W;
    localparam logic [31:0] CTL1_OFF = 32'd4;
    localparam logic [31:0] BUFP_OFF = 32'd8;

    typedef enum logic [3:0] {
        S_IDLE, S_RD0, S_RD1, S_RD2, S_RECV, S_WRW, S_DROP, S_SKIP, S_WB
    } rxd_state_t;
endpackage

// File: rtl/rxd_ring_ptr.sv
// Ring base register and entry index; produces the current descriptor address.
// Assumes base writes happen while no frame is in progress.
module rxd_ring_ptr #(
    parameter int IDX_W = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        base_we,
    input  logic [31:0] base_in,
    input  logic        adv,
    input  logic        wrap,
    output logic [31:0] desc_addr
);
    localparam int ZPAD = 32 - IDX_W;

    logic [31:0]      base_q;
    logic [IDX_W-1:0] idx_q;

    // Base register load (16-byte aligned) and index stepping / wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            idx_q  <= '0;
        end else if (base_we) begin
            base_q <= base_in & ~32'hF;
            idx_q  <= '0;
        end else if (adv) begin
            idx_q <= wrap ? '0 : idx_q + 1'b1;
        end
    end

    assign desc_addr = base_q + ({{ZPAD{1'b0}}, idx_q} << 4);
endmodule

// File: rtl/rxd_packer.sv
// Gathers frame bytes into one memory word with per-lane enables.
// Assumes bytes arrive in ascending address order and a clear follows a full word.
module rxd_packer (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_addr,
    input  logic        push,
    input  logic [7:0]  push_byte,
    input  logic        clear,
    output logic [31:0] word,
    output logic [3:0]  be,
    output logic [29:0] waddr,
    output logic        full,
    output logic        pend
);
    logic [31:0] ptr_q;
    logic [31:0] word_q;
    logic [3:0]  be_q;
    logic [29:0] wa_q;
    logic [1:0]  lane;

    assign lane = ptr_q[1:0];

    // Byte pointer, word assembly and lane enables.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q  <= '0;
            word_q <= '0;
            be_q   <= '0;
            wa_q   <= '0;
        end else if (load) begin
            ptr_q  <= load_addr;
            word_q <= '0;
            be_q   <= '0;
        end else begin
            if (clear) begin
                word_q <= '0;
                be_q   <= '0;
            end
            if (push) begin
                word_q[{lane, 3'b000} +: 8] <= push_byte;
                be_q[lane] <= 1'b1;
                ptr_q      <= ptr_q + 32'd1;
                if (be_q == 4'b0000) wa_q <= ptr_q[31:2];
            end
        end
    end

    assign word  = word_q;
    assign be    = be_q;
    assign waddr = wa_q;
    assign full  = be_q[3];
    assign pend  = |be_q;
endmodule

// File: rtl/rxd_engine.sv
// Frame sequencer: fetches the descriptor, checks ownership and buffer
// address, streams bytes through the packer, and writes back status.
// Assumes one outstanding memory request and a frame starts with rx_sof.
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_valid,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    output logic              rx_ready,
    input  logic [31:0]       desc_addr,
    output logic              ptr_adv,
    output logic              ptr_wrap,
    output logic              pk_load,
    output logic [31:0]       pk_load_addr,
    output logic              pk_push,
    output logic              pk_clear,
    input  logic              pk_full,
    input  logic              pk_pend,
    input  logic [31:0]       pk_word,
    input  logic [3:0]        pk_be,
    input  logic [29:0]       pk_waddr,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              wb_done,
    output logic [MISS_W-1:0] missed_count
);
    rxd_state_t        state_q;
    logic [LEN_W-1:0]  size_q;
    logic [LEN_W-1:0]  cnt_q;
    logic              eor_q, ovf_q, err_q, bad_q, eof_q, done_q;
    logic [MISS_W-1:0] miss_q;
    logic              accept, room, bad_addr;
    logic [31:0]       wb_word;

    assign accept   = rx_valid && rx_ready;
    assign room     = cnt_q < size_q;
    assign bad_addr = mem_rdata[0] || !mem_rdata[1];
    assign wb_word  = {1'b0, err_q, ovf_q, bad_q, {PAD_W{1'b0}}, cnt_q};

    // Handshake and memory request decode for the current state.
    always_comb begin
        rx_ready  = 1'b0;
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = desc_addr;
        mem_wdata = '0;
        mem_be    = 4'hF;
        case (state_q)
            S_IDLE: rx_ready = !(rx_valid && rx_sof);
            S_RD0:  mem_req  = 1'b1;
            S_RD1: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + CTL1_OFF;
            end
            S_RD2: begin
                mem_req  = 1'b1;
                mem_addr = desc_addr + BUFP_OFF;
            end
            S_RECV: rx_ready = !eof_q && !pk_full;
            S_WRW: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {pk_waddr, 2'b00};
                mem_wdata = pk_word;
                mem_be    = pk_be;
            end
            S_DROP, S_SKIP: rx_ready = 1'b1;
            S_WB: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = wb_word;
            end
            default: ;
        endcase
    end

    // Sequencing, per-frame status capture and the missed-frame count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            size_q  <= '0;
            cnt_q   <= '0;
            eor_q   <= 1'b0;
            ovf_q   <= 1'b0;
            err_q   <= 1'b0;
            bad_q   <= 1'b0;
            eof_q   <= 1'b0;
            done_q  <= 1'b0;
            miss_q  <= '0;
        end else begin
            done_q <= (state_q == S_WB) && mem_ack;
            case (state_q)
                S_IDLE: if (rx_valid && rx_sof) state_q <= S_RD0;
                S_RD0: if (mem_ack) begin
                    if (mem_rdata[OWN_BIT]) begin
                        state_q <= S_RD1;
                    end else begin
                        miss_q  <= miss_q + 1'b1;
                        state_q <= S_DROP;
                    end
                end
                S_RD1: if (mem_ack) begin
                    size_q  <= mem_rdata[LEN_W-1:0];
                    eor_q   <= mem_rdata[EOR_BIT];
                    state_q <= S_RD2;
                end
                S_RD2: if (mem_ack) begin
                    cnt_q   <= '0;
                    ovf_q   <= 1'b0;
                    err_q   <= 1'b0;
                    eof_q   <= 1'b0;
                    bad_q   <= bad_addr;
                    state_q <= bad_addr ? S_SKIP : S_RECV;
                end
                S_RECV: begin
                    if (accept) begin
                        if (room) cnt_q <= cnt_q + 1'b1;
                        else      ovf_q <= 1'b1;
                        if (rx_eof) begin
                            eof_q <= 1'b1;
                            err_q <= rx_err;
                        end
                    end else if (eof_q) begin
                        state_q <= pk_pend ? S_WRW : S_WB;
                    end else if (pk_full) begin
                        state_q <= S_WRW;
                    end
                end
                S_WRW:  if (mem_ack) state_q <= S_RECV;
                S_DROP: if (accept && rx_eof) state_q <= S_IDLE;
                S_SKIP: if (accept && rx_eof) state_q <= S_WB;
                S_WB:   if (mem_ack) state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    assign pk_load      = (state_q == S_RD2) && mem_ack && !bad_addr;
    assign pk_load_addr = mem_rdata;
    assign pk_push      = (state_q == S_RECV) && accept && room;
    assign pk_clear     = (state_q == S_WRW) && mem_ack;
    assign ptr_adv      = (state_q == S_WB) && mem_ack;
    assign ptr_wrap     = eor_q;
    assign wb_done      = done_q;
    assign missed_count = miss_q;
endmodule

// File: rtl/rxd_dma_writer.sv
// Top of the receive descriptor ring writer: ring pointer, byte packer and
// frame sequencer. Assumes memory at the far side acknowledges every request.
module rxd_dma_writer #(
    parameter int IDX_W  = 8,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_we,
    input  logic [31:0]       base_addr,
    input  logic              rx_valid,
    output logic              rx_ready,
    input  logic [7:0]        rx_data,
    input  logic              rx_sof,
    input  logic              rx_eof,
    input  logic              rx_err,
    output logic              mem_req,
    output logic              mem_we,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    output logic [3:0]        mem_be,
    input  logic              mem_ack,
    input  logic [31:0]       mem_rdata,
    output logic              wb_done,
    output logic [MISS_W-1:0] missed_count
);
    logic [31:0] desc_addr;
    logic        ptr_adv, ptr_wrap;
    logic        pk_load, pk_push, pk_clear, pk_full, pk_pend;
    logic [31:0] pk_load_addr, pk_word;
    logic [3:0]  pk_be;
    logic [29:0] pk_waddr;

    rxd_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .base_we   (base_we),
        .base_in   (base_addr),
        .adv       (ptr_adv),
        .wrap      (ptr_wrap),
        .desc_addr (desc_addr)
    );

    rxd_packer u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pk_load),
        .load_addr (pk_load_addr),
        .push      (pk_push),
        .push_byte (rx_data),
        .clear     (pk_clear),
        .word      (pk_word),
        .be        (pk_be),
        .waddr     (pk_waddr),
        .full      (pk_full),
        .pend      (pk_pend)
    );

    rxd_engine #(.MISS_W(MISS_W)) u_eng (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_valid     (rx_valid),
        .rx_sof       (rx_sof),
        .rx_eof       (rx_eof),
        .rx_err       (rx_err),
        .rx_ready     (rx_ready),
        .desc_addr    (desc_addr),
        .ptr_adv      (ptr_adv),
        .ptr_wrap     (ptr_wrap),
        .pk_load      (pk_load),
        .pk_load_addr (pk_load_addr),
        .pk_push      (pk_push),
        .pk_clear     (pk_clear),
        .pk_full      (pk_full),
        .pk_pend      (pk_pend),
        .pk_word      (pk_word),
        .pk_be        (pk_be),
        .pk_waddr     (pk_waddr),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_be       (mem_be),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .wb_done      (wb_done),
        .missed_count (missed_count)
    );
endmodule

// File: rtl/rxd_dma_chk.sv
// Port-level protocol checks for the receive ring writer, bound to the top.
module rxd_dma_chk #(
    parameter int MISS_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [31:0]       mem_addr,
    input logic [31:0]       mem_wdata,
    input logic [3:0]        mem_be,
    input logic              mem_ack,
    input logic              wb_done,
    input logic [MISS_W-1:0] missed_count
);
    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)
            && $stable(mem_wdata) && $stable(mem_be));

    // R2
    word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> mem_addr[1:0] == 2'b00);

    // R5
    write_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_be != 4'b0000);

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |=> !wb_done);

    // R9
    done_after_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wb_done |-> $past(mem_req && mem_we && mem_ack));

    // R3
    miss_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        missed_count != $past(missed_count)
            |-> missed_count == $past(missed_count) + {{(MISS_W-1){1'b0}}, 1'b1});
endmodule

bind rxd_dma_writer rxd_dma_chk #(.MISS_W(MISS_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .mem_req      (mem_req),
    .mem_we       (mem_we),
    .mem_addr     (mem_addr),
    .mem_wdata    (mem_wdata),
    .mem_be       (mem_be),
    .mem_ack      (mem_ack),
    .wb_done      (wb_done),
    .missed_count (missed_count)
);

// File: tb/sim_rxd_dma_writer.sv
// Bench: behavioural memory with varying latency, a descriptor-ring model,
// and a write-address check against that model on every memory write.
module sim_rxd_dma_writer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0;
    logic [31:0] base_addr = '0;
    logic        rx_valid = 1'b0;
    logic        rx_ready;
    logic [7:0]  rx_data = '0;
    logic        rx_sof = 1'b0;
    logic        rx_eof = 1'b0;
    logic        rx_err = 1'b0;
    logic        mem_req, mem_we;
    logic [31:0] mem_addr, mem_wdata;
    logic [3:0]  mem_be;
    logic        ack_q = 1'b0;
    logic [31:0] rdata_q = '0;
    logic        wb_done;
    logic [15:0] missed_count;

    always #10 clk = ~clk;

    rxd_dma_writer u0 (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_addr(base_addr),
        .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_be(mem_be), .mem_ack(ack_q),
        .mem_rdata(rdata_q), .wb_done(wb_done), .missed_count(missed_count)
    );

    logic [31:0] mem [0:1023];
    integer nchk = 0, nerr = 0, acc_cnt = 0, wcnt = 0, done_cnt = 0;
    logic        allow_on = 1'b0;
    logic [31:0] allow_desc = '0, allow_lo = '0, allow_hi = '0;
    logic [31:0] m_base = '0;
    integer      m_idx = 0;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        nchk = nchk + 1;
        if (!ok) begin
            nerr = nerr + 1;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rd_byte(input logic [31:0] a);
        return 8'(mem[a[11:2]] >> (a[1:0] * 8));
    endfunction

    function automatic logic [7:0] pat(input integer seed, input integer k);
        return 8'(seed * 13 + k * 7 + 1);
    endfunction

    function automatic bit wr_ok(input logic [31:0] a, input logic [3:0] be);
        bit ok = allow_on;
        if (a == allow_desc && be == 4'hF) return ok;
        for (int l = 0; l < 4; l++)
            if (be[l] && !((a + l) >= allow_lo && (a + l) < allow_hi)) ok = 0;
        return ok;
    endfunction

    // Memory responder: latency 0..2 wait cycles, write-address check per write.
    always @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            wcnt  <= 0;
        end else if (ack_q) begin
            ack_q <= 1'b0;
            wcnt  <= 0;
        end else if (mem_req) begin
            if (wcnt >= acc_cnt % 3) begin
                ack_q   <= 1'b1;
                acc_cnt <= acc_cnt + 1;
                if (mem_we) begin
                    chk(wr_ok(mem_addr, mem_be), "R5 write inside expected buffer or descriptor",
                        mem_addr, allow_desc);
                    for (int l = 0; l < 4; l++)
                        if (mem_be[l]) mem[mem_addr[11:2]][l*8 +: 8] <= mem_wdata[l*8 +: 8];
                end else begin
                    rdata_q <= mem[mem_addr[11:2]];
                end
            end else begin
                wcnt <= wcnt + 1;
            end
        end
    end

    always @(posedge clk) if (rst_n && wb_done) done_cnt <= done_cnt + 1;

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        nchk = nchk + 1;
        nerr = nerr + 1;
        $display("FAIL watchdog: actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    task automatic put_desc(input logic [31:0] base, input integer i, input bit own,
                            input integer size, input bit eor, input logic [31:0] bp);
        logic [31:0] d = base + 32'(16 * i);
        mem[d[11:2]]       = {own, 31'b0};
        mem[(d + 4) >> 2]  = {eor, 20'b0, 11'(size)};
        mem[(d + 8) >> 2]  = bp;
    endtask

    task automatic write_base(input logic [31:0] a);
        @(negedge clk);
        base_we = 1'b1;
        base_addr = a;
        @(negedge clk);
        base_we = 1'b0;
        m_base = a & ~32'hF;
        m_idx = 0;
    endtask

    task automatic send_frame(input integer n, input bit err, input integer seed, input bit framed);
        for (int k = 0; k < n; k++) begin
            bit taken = 0;
            while (!taken) begin
                @(negedge clk);
                rx_valid = 1'b1;
                rx_data  = pat(seed, k);
                rx_sof   = framed && (k == 0);
                rx_eof   = framed && (k == n - 1);
                rx_err   = framed && (k == n - 1) && err;
                #1;
                taken = rx_ready;
                @(posedge clk);
            end
        end
        @(negedge clk);
        rx_valid = 1'b0;
        rx_sof = 1'b0;
        rx_eof = 1'b0;
        rx_err = 1'b0;
    endtask

    task automatic run_frame(input integer n, input bit err, input integer seed, input string tag);
        logic [31:0] d  = m_base + 32'(16 * m_idx);
        logic [31:0] c0 = mem[d[11:2]];
        logic [31:0] c1 = mem[(d + 4) >> 2];
        logic [31:0] bp = mem[(d + 8) >> 2];
        bit own = c0[31];
        integer size = integer'(c1[10:0]);
        bit eor = c1[31];
        bit bad = bp[0] || !bp[1];
        integer stored = (own && !bad) ? ((n > size) ? size : n) : 0;
        logic [7:0] g_lo = rd_byte(bp - 1);
        logic [7:0] g_hi = rd_byte(bp + 32'(stored));
        logic [15:0] miss0 = missed_count;
        integer done0 = done_cnt;
        logic [31:0] exp0;
        integer mism = 0;
        allow_on = own;
        allow_desc = d;
        allow_lo = bp;
        allow_hi = bp + 32'(stored);
        send_frame(n, err, seed, 1'b1);
        if (!own) begin
            repeat (8) @(negedge clk);
            chk(missed_count == miss0 + 16'd1, "R3 missed count step", 32'(missed_count), 32'(miss0 + 16'd1));
            chk(mem[d[11:2]] == c0, "R3 owned-by-software descriptor untouched", mem[d[11:2]], c0);
            chk(done_cnt == done0, "R3 no write-back pulse", done_cnt, done0);
        end else begin
            for (int w = 0; w < 400 && done_cnt == done0; w++) @(negedge clk);
            repeat (3) @(negedge clk);
            if (bad) exp0 = 32'h1000_0000;
            else     exp0 = {1'b0, err, (n > size), 1'b0, 17'b0, 11'(stored)};
            chk(mem[d[11:2]] == exp0, tag, mem[d[11:2]], exp0);
            if (!bad) begin
                for (int k = 0; k < stored; k++)
                    if (rd_byte(bp + 32'(k)) != pat(seed, k)) mism = mism + 1;
                chk(mism == 0, "R5 stored bytes in lane order", mism, 0);
                chk(rd_byte(bp - 1) == g_lo, "R5 byte before buffer untouched", rd_byte(bp - 1), g_lo);
                chk(rd_byte(bp + 32'(stored)) == g_hi, "R6 byte after stored data untouched",
                    rd_byte(bp + 32'(stored)), g_hi);
            end
            chk(missed_count == miss0, "R3 missed count unchanged on accepted frame", 32'(missed_count), 32'(miss0));
            chk(done_cnt == done0 + 1, "R9 one write-back pulse", done_cnt, done0 + 1);
            m_idx = eor ? 0 : m_idx + 1;
        end
        allow_on = 1'b0;
    endtask

    initial begin
        integer acc0;
        for (int i = 0; i < 1024; i++) mem[i] = 32'hA5A5_A5A5;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(mem_req == 1'b0, "R11 reset: no request", 32'(mem_req), 0);
        chk(wb_done == 1'b0, "R9 reset: no pulse", 32'(wb_done), 0);
        chk(missed_count == 16'd0, "R3 reset: missed count zero", 32'(missed_count), 0);

        // Ring of four at 0x100; entry 3 has a word-aligned buffer and ends the ring.
        put_desc(32'h100, 0, 1, 64, 0, 32'h402);
        put_desc(32'h100, 1, 1, 64, 0, 32'h482);
        put_desc(32'h100, 2, 1, 20, 0, 32'h502);
        put_desc(32'h100, 3, 1, 64, 1, 32'h5C0);
        write_base(32'h10B);

        run_frame(10, 0, 1, "R2 R7 first frame into entry 0 (base low bits ignored, R1)");
        run_frame(5, 1, 2, "R7 error marker reported in bit 30");
        run_frame(30, 0, 3, "R6 truncated to size with bit 29");
        run_frame(7, 0, 4, "R4 word-aligned buffer rejected");
        run_frame(6, 0, 5, "R3 drop on wrapped entry");
        run_frame(3, 0, 6, "R3 second drop stays on entry");

        // Re-arm entry 0; give entry 1 an odd buffer address.
        put_desc(32'h100, 0, 1, 64, 0, 32'h402);
        put_desc(32'h100, 1, 1, 64, 0, 32'h483);
        run_frame(1, 0, 7, "R8 wrap to entry 0 after end flag, single-byte frame");
        run_frame(4, 0, 8, "R4 odd buffer address rejected");

        // Stray bytes while idle, no start marker.
        acc0 = acc_cnt;
        send_frame(5, 0, 9, 1'b0);
        repeat (6) @(negedge clk);
        chk(acc_cnt == acc0, "R10 stray bytes cause no memory access", acc_cnt, acc0);
        chk(missed_count == 16'd2, "R10 stray bytes not counted as missed", 32'(missed_count), 2);

        // New two-entry ring at 0x200 while the old ring sits at entry 2.
        put_desc(32'h200, 0, 1, 64, 0, 32'h602);
        put_desc(32'h200, 1, 1, 64, 1, 32'h682);
        write_base(32'h200);
        run_frame(9, 0, 10, "R1 base write restarts at entry 0");
        run_frame(64, 0, 11, "R6 frame of exactly buffer size not truncated");
        put_desc(32'h200, 0, 1, 64, 0, 32'h602);
        run_frame(12, 1, 12, "R8 two-entry ring wraps to entry 0");
        chk(missed_count == 16'd2, "R3 final missed count", 32'(missed_count), 2);

        finish_run();
    end
endmodule